// File: doc/BRIEF.md
# Multi-mode down-counter channel

One timer channel of a programmable interval timer. A WIDTH-bit counter steps down on each falling edge of an external count clock and drives a single waveform output. A 3-bit mode code selects one of six behaviours: a terminal-count flag, a gate-triggered one-shot, a periodic rate divider, a square-wave divider, a strobe started by software and a strobe started by the gate. Both the count clock and the gate are asynchronous to the system clock. Each passes through its own synchroniser before its edges are detected.

A register block above this channel writes the mode and the reload value through two one-cycle write strobes. The live count is a plain output that the register block latches when it needs to. A reload value of 0 stands for the full counter range. In the two periodic modes a reload value of 1 is refused and flagged, and the channel carries on as before.

Top module: `dcnt_channel`

## Requirements
- R1: After reset the count is 0, the output is high, the error flag is low and the channel is idle in mode 0.
- R2: A mode write clears the count and the stored reload value, clears the error flag and stops counting. The output goes low for mode 0 and high for every other mode. Codes 6 and 7 behave as modes 2 and 3.
- R3: The count changes only on a falling edge of the synchronised count clock or on a write or gate trigger. A rising edge of the count clock has no effect.
- R4: Mode 0. A reload write loads the count and drives the output low. The output rises when the count steps to 0. The count then holds at 0 and the output stays high until the next reload write. A reload value of 0 first steps to 0xFFFF.
- R5: Mode 1. A reload write only arms the channel. A gate rising edge loads the count and drives the output low. The output returns high when the count reaches 0. A later gate edge restarts the count, and this also applies while the count is running.
- R6: Mode 2. The count reloads from the stored value on the step after it reaches 1. The output is low exactly while the count is 1. A reload value of 0 steps from 0 to 0xFFFF.
- R7: Mode 3. The count steps down by two and starts from the reload value with bit 0 cleared. When a step finds the count at 2, the count reloads and the output toggles. A reload value of 0 steps from 0 to 0xFFFE.
- R8: Mode 4. A reload write starts the count with the output high. When the count reaches 0 the output goes low for one count-clock period. After that it returns high and the channel stays idle.
- R9: Mode 5. A reload write arms the channel. A gate rising edge starts the count. The output strobes low for one count-clock period at 0, and the channel then re-arms for the next gate edge.
- R10: In modes 0 and 4 a gate edge changes neither the count nor the output.
- R11: In modes 2 and 3 a reload value of 1 sets the error flag and leaves the count and the stored reload value unchanged. The next accepted reload write clears the flag.
- R12: In modes 2 and 3 a reload write made while counting does not disturb the current count. It takes effect at the next reload point.
- R13: In modes 2 and 3 a gate rising edge restarts the count from the stored reload value and sets the output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clk_in | input | 1 | Asynchronous count clock; counting happens on its falling edge |
| gate_in | input | 1 | Asynchronous gate; its rising edge triggers in modes 1, 2, 3 and 5 |
| mode_wr | input | 1 | One-cycle strobe that writes mode_code |
| mode_code | input | 3 | Operating mode code 0 to 7 (6 and 7 alias to 2 and 3) |
| preset_wr | input | 1 | One-cycle strobe that writes preset_val |
| preset_val | input | WIDTH (16) | Reload value; 0 means the full range |
| count_q | output | WIDTH (16) | Live count, for latching |
| wave_out | output | 1 | Mode-dependent output waveform |
| preset_err | output | 1 | High after a refused reload value of 1 in mode 2 or 3 |

## Verification
The assertions assume that the write strobes last a single system clock and never coincide with each other. They also assume that a count-clock falling edge and a gate rising edge never arrive in the same system cycle as a write. The per-mode waveform checks further assume that each level of the count clock and the gate is held for several system clocks, so that every edge gets through the synchroniser on its own. The stimulus drives all inputs on the falling system-clock edge, issues writes one at a time, and holds each count-clock and gate level for four or five system cycles. The design outputs are sampled only after every event has fully propagated.

// File: rtl/dcnt_pkg.sv
`timescale 1ns/1ps
// Shared types for the down-counter channel: mode codes, phase states
// and the decode that folds the two alias codes onto the periodic modes.
package dcnt_pkg;

    typedef enum logic [2:0] {
        M_TC_FLAG   = 3'd0,
        M_ONESHOT   = 3'd1,
        M_RATE      = 3'd2,
        M_SQUARE    = 3'd3,
        M_SW_STROBE = 3'd4,
        M_HW_STROBE = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ARMED  = 2'd1,
        PH_RUN    = 2'd2,
        PH_STROBE = 2'd3
    } phase_e;

    // Codes 6 and 7 select the periodic modes 2 and 3.
    function automatic mode_e decode_mode(input logic [2:0] code);
        if (code[2:1] == 2'b11) return mode_e'({1'b0, code[1:0]});
        return mode_e'(code);
    endfunction

    // True for modes in which a gate rising edge acts as a trigger.
    function automatic logic gate_sensitive(input mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HW_STROBE);
    endfunction

endpackage

// File: rtl/dcnt_sync_edge.sv
`timescale 1ns/1ps
// Synchroniser with edge detect.
// Brings an asynchronous level into the clk domain through STAGES flops
// and gives a one-cycle pulse on the edge that FALLING selects.
// Assumes each input level lasts longer than STAGES+1 system clocks.
module dcnt_sync_edge #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_hit
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], async_in};
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[LAST];
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_hit = prev & ~chain[LAST];
        end else begin : g_rise
            assign edge_hit = ~prev & chain[LAST];
        end
    endgenerate

endmodule

// File: rtl/dcnt_cfg.sv
`timescale 1ns/1ps
// Configuration holder: the active mode, the stored reload value and the
// refused-value flag. Decides whether a reload write is accepted.
// Assumes mode_wr and preset_wr are single-cycle strobes; mode_wr wins.
module dcnt_cfg
    import dcnt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [2:0]       mode_code,
    input  logic             preset_wr,
    input  logic [WIDTH-1:0] preset_val,
    output mode_e            mode_q,
    output logic [WIDTH-1:0] preset_q,
    output logic             err_q,
    output logic             load_ok
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic refuse;

    assign refuse  = ((mode_q == M_RATE) || (mode_q == M_SQUARE)) && (preset_val == ONE);
    assign load_ok = preset_wr && !mode_wr && !refuse;

    // Hold mode, reload value and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= M_TC_FLAG;
            preset_q <= '0;
            err_q    <= 1'b0;
        end else if (mode_wr) begin
            mode_q   <= decode_mode(mode_code);
            preset_q <= '0;
            err_q    <= 1'b0;
        end else if (preset_wr) begin
            if (refuse) begin
                err_q <= 1'b1;
            end else begin
                preset_q <= preset_val;
                err_q    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dcnt_engine.sv
`timescale 1ns/1ps
// Counting engine: the down-counter, its phase and the output waveform.
// Priority per cycle: mode write, accepted load, gate trigger, count step.
// Assumes tick and trig are single-cycle pulses from the synchronisers.
module dcnt_engine
    import dcnt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic             mode_wr,
    input  logic [2:0]       mode_code,
    input  logic             load_ok,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] preset_q,
    input  logic             tick,
    input  logic             trig,
    output logic [WIDTH-1:0] count_q,
    output logic             out_q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
    localparam logic [WIDTH-1:0] TWO = WIDTH'(2);

    phase_e phase;
    logic   trig_live;

    // Square-wave start point: odd values lose their low bit.
    function automatic logic [WIDTH-1:0] even_of(input logic [WIDTH-1:0] v);
        return {v[WIDTH-1:1], 1'b0};
    endfunction

    assign trig_live = trig && (phase != PH_IDLE) && gate_sensitive(mode);

    // Advance count, phase and output for the event of highest priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            out_q   <= 1'b1;
            phase   <= PH_IDLE;
        end else if (mode_wr) begin
            count_q <= '0;
            out_q   <= (decode_mode(mode_code) != M_TC_FLAG);
            phase   <= PH_IDLE;
        end else if (load_ok) begin
            case (mode)
                M_TC_FLAG: begin
                    count_q <= load_val;
                    out_q   <= 1'b0;
                    phase   <= PH_RUN;
                end
                M_SW_STROBE: begin
                    count_q <= load_val;
                    out_q   <= 1'b1;
                    phase   <= PH_RUN;
                end
                M_ONESHOT, M_HW_STROBE: begin
                    if (phase == PH_IDLE) phase <= PH_ARMED;
                end
                M_RATE: begin
                    if (phase == PH_IDLE) begin
                        count_q <= load_val;
                        out_q   <= 1'b1;
                        phase   <= PH_RUN;
                    end
                end
                M_SQUARE: begin
                    if (phase == PH_IDLE) begin
                        count_q <= even_of(load_val);
                        out_q   <= 1'b1;
                        phase   <= PH_RUN;
                    end
                end
                default: ;
            endcase
        end else if (trig_live) begin
            phase <= PH_RUN;
            case (mode)
                M_ONESHOT: begin
                    count_q <= preset_q;
                    out_q   <= 1'b0;
                end
                M_SQUARE: begin
                    count_q <= even_of(preset_q);
                    out_q   <= 1'b1;
                end
                default: begin
                    count_q <= preset_q;
                    out_q   <= 1'b1;
                end
            endcase
        end else if (tick && (phase == PH_RUN)) begin
            case (mode)
                M_TC_FLAG, M_ONESHOT: begin
                    if (count_q == ONE) begin
                        count_q <= '0;
                        out_q   <= 1'b1;
                        phase   <= (mode == M_ONESHOT) ? PH_ARMED : PH_IDLE;
                    end else begin
                        count_q <= count_q - ONE;
                    end
                end
                M_RATE: begin
                    if (count_q == ONE) begin
                        count_q <= preset_q;
                        out_q   <= 1'b1;
                    end else begin
                        count_q <= count_q - ONE;
                        out_q   <= (count_q != TWO);
                    end
                end
                M_SQUARE: begin
                    if (count_q == TWO) begin
                        count_q <= even_of(preset_q);
                        out_q   <= ~out_q;
                    end else begin
                        count_q <= count_q - TWO;
                    end
                end
                default: begin
                    if (count_q == ONE) begin
                        count_q <= '0;
                        out_q   <= 1'b0;
                        phase   <= PH_STROBE;
                    end else begin
                        count_q <= count_q - ONE;
                    end
                end
            endcase
        end else if (tick && (phase == PH_STROBE)) begin
            out_q <= 1'b1;
            phase <= (mode == M_HW_STROBE) ? PH_ARMED : PH_IDLE;
        end
    end

endmodule

// File: rtl/dcnt_channel.sv
`timescale 1ns/1ps
// Top of one down-counter channel: synchronises the count clock and gate,
// holds the configuration and runs the counting engine.
// Assumes the register block above issues single-cycle write strobes.
module dcnt_channel
    import dcnt_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clk_in,
    input  logic             gate_in,
    input  logic             mode_wr,
    input  logic [2:0]       mode_code,
    input  logic             preset_wr,
    input  logic [WIDTH-1:0] preset_val,
    output logic [WIDTH-1:0] count_q,
    output logic             wave_out,
    output logic             preset_err
);
    logic             tclk_fall;
    logic             gate_rise;
    mode_e            mode_q;
    logic [WIDTH-1:0] preset_q;
    logic             load_ok;

    dcnt_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_tclk_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cnt_clk_in),
        .edge_hit (tclk_fall)
    );

    dcnt_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_gate_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (gate_in),
        .edge_hit (gate_rise)
    );

    dcnt_cfg #(.WIDTH(WIDTH)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_code  (mode_code),
        .preset_wr  (preset_wr),
        .preset_val (preset_val),
        .mode_q     (mode_q),
        .preset_q   (preset_q),
        .err_q      (preset_err),
        .load_ok    (load_ok)
    );

    dcnt_engine #(.WIDTH(WIDTH)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .mode_wr   (mode_wr),
        .mode_code (mode_code),
        .load_ok   (load_ok),
        .load_val  (preset_val),
        .preset_q  (preset_q),
        .tick      (tclk_fall),
        .trig      (gate_rise),
        .count_q   (count_q),
        .out_q     (wave_out)
    );

endmodule

// File: rtl/dcnt_channel_chk.sv
`timescale 1ns/1ps
// Property checker for dcnt_channel, attached with bind below.
// Assumes writes, count-clock falls and gate rises do not coincide.
module dcnt_channel_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic [2:0]       mode_code,
    input logic             preset_wr,
    input logic [WIDTH-1:0] preset_val,
    input logic [WIDTH-1:0] count_q,
    input logic             wave_out,
    input logic             preset_err,
    input logic [2:0]       mode_q,
    input logic             tclk_fall,
    input logic             gate_rise
);
    // Mode write clears count and error flag.
    assert_mode_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (count_q == '0) && !preset_err);

    // Without any event the count holds.
    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tclk_fall && !gate_rise && !mode_wr && !preset_wr) |=> $stable(count_q));

    // Writing mode 0 pulls the output low.
    assert_mode0_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && (mode_code == 3'd0)) |=> !wave_out);

    // Rate mode output falls only as the count reaches 1.
    assert_rate_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == 3'd2) && $fell(wave_out)) |-> (count_q == WIDTH'(1)));

    // Square-wave count is always even.
    assert_square_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd3) |-> !count_q[0]);

    // Software strobe falls only at count 0.
    assert_strobe_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == 3'd4) && $fell(wave_out)) |-> (count_q == '0));

    // A refused value of 1 flags and leaves the count alone.
    assert_refuse_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_wr && !mode_wr && !tclk_fall && !gate_rise &&
         ((mode_q == 3'd2) || (mode_q == 3'd3)) && (preset_val == WIDTH'(1)))
        |=> preset_err && $stable(count_q));

endmodule

bind dcnt_channel dcnt_channel_chk #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_code  (mode_code),
    .preset_wr  (preset_wr),
    .preset_val (preset_val),
    .count_q    (count_q),
    .wave_out   (wave_out),
    .preset_err (preset_err),
    .mode_q     (mode_q),
    .tclk_fall  (tclk_fall),
    .gate_rise  (gate_rise)
);

// File: tb/dcnt_channel_tb_top.sv
`timescale 1ns/1ps
// Directed bench for dcnt_channel: one task per scenario, each checking itself.
module dcnt_channel_tb_top;

    localparam int WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_clk_in = 1'b0;
    logic             gate_in = 1'b0;
    logic             mode_wr = 1'b0;
    logic [2:0]       mode_code = 3'd0;
    logic             preset_wr = 1'b0;
    logic [WIDTH-1:0] preset_val = '0;
    logic [WIDTH-1:0] count_q;
    logic             wave_out;
    logic             preset_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dcnt_channel #(.WIDTH(WIDTH), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_clk_in (cnt_clk_in),
        .gate_in    (gate_in),
        .mode_wr    (mode_wr),
        .mode_code  (mode_code),
        .preset_wr  (preset_wr),
        .preset_val (preset_val),
        .count_q    (count_q),
        .wave_out   (wave_out),
        .preset_err (preset_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [2:0] c);
        @(negedge clk);
        mode_code = c;
        mode_wr   = 1'b1;
        @(negedge clk);
        mode_wr   = 1'b0;
        idle(1);
    endtask

    task automatic wr_preset(input logic [WIDTH-1:0] v);
        @(negedge clk);
        preset_val = v;
        preset_wr  = 1'b1;
        @(negedge clk);
        preset_wr  = 1'b0;
        idle(1);
    endtask

    task automatic step_clk(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_clk_in = 1'b1;
            idle(4);
            cnt_clk_in = 1'b0;
            idle(5);
        end
    endtask

    task automatic gate_pulse();
        gate_in = 1'b1;
        idle(5);
        gate_in = 1'b0;
        idle(4);
    endtask

    task automatic t_reset();
        check("R1", "count", count_q, 0);
        check("R1", "out", wave_out, 1);
        check("R1", "err", preset_err, 0);
    endtask

    task automatic t_mode0();
        wr_mode(3'd0);
        check("R2", "mode0 out low", wave_out, 0);
        wr_preset(16'd3);
        check("R4", "load count", count_q, 3);
        check("R4", "load out", wave_out, 0);
        cnt_clk_in = 1'b1;
        idle(6);
        check("R3", "rising clk no step", count_q, 3);
        cnt_clk_in = 1'b0;
        idle(5);
        check("R3", "falling clk step", count_q, 2);
        gate_pulse();
        check("R10", "mode0 gate count", count_q, 2);
        check("R10", "mode0 gate out", wave_out, 0);
        step_clk(1);
        check("R4", "count 1 out", wave_out, 0);
        step_clk(1);
        check("R4", "reach 0 count", count_q, 0);
        check("R4", "reach 0 out", wave_out, 1);
        step_clk(1);
        check("R4", "hold 0 count", count_q, 0);
        check("R4", "hold 0 out", wave_out, 1);
        wr_preset(16'd0);
        step_clk(1);
        check("R4", "preset 0 wrap", count_q, 16'hFFFF);
        check("R4", "preset 0 out", wave_out, 0);
    endtask

    task automatic t_mode1();
        wr_mode(3'd1);
        check("R2", "mode1 out high", wave_out, 1);
        check("R2", "mode1 count clear", count_q, 0);
        wr_preset(16'd2);
        step_clk(1);
        check("R5", "armed no count", count_q, 0);
        gate_pulse();
        check("R5", "trigger count", count_q, 2);
        check("R5", "trigger out", wave_out, 0);
        step_clk(1);
        check("R5", "step count", count_q, 1);
        step_clk(1);
        check("R5", "end count", count_q, 0);
        check("R5", "end out", wave_out, 1);
        gate_pulse();
        step_clk(1);
        check("R5", "second shot count", count_q, 1);
        gate_pulse();
        check("R5", "retrigger count", count_q, 2);
        check("R5", "retrigger out", wave_out, 0);
    endtask

    task automatic t_mode2();
        wr_mode(3'd2);
        wr_preset(16'd3);
        check("R6", "load count", count_q, 3);
        step_clk(1);
        check("R6", "count 2 out", wave_out, 1);
        step_clk(1);
        check("R6", "count 1", count_q, 1);
        check("R6", "count 1 out low", wave_out, 0);
        step_clk(1);
        check("R6", "reload", count_q, 3);
        check("R6", "reload out", wave_out, 1);
        wr_preset(16'd5);
        check("R12", "late load no disturb", count_q, 3);
        step_clk(3);
        check("R12", "new preset at reload", count_q, 5);
        step_clk(1);
        gate_pulse();
        check("R13", "gate restart count", count_q, 5);
        check("R13", "gate restart out", wave_out, 1);
        wr_preset(16'd1);
        check("R11", "refuse flag", preset_err, 1);
        check("R11", "refuse count", count_q, 5);
        step_clk(5);
        check("R11", "preset kept", count_q, 5);
        wr_preset(16'd4);
        check("R11", "flag cleared", preset_err, 0);
        wr_mode(3'd2);
        wr_preset(16'd0);
        check("R6", "preset 0 load", count_q, 0);
        step_clk(1);
        check("R6", "preset 0 wrap", count_q, 16'hFFFF);
        wr_mode(3'd6);
        wr_preset(16'd1);
        check("R2", "code 6 acts as rate", preset_err, 1);
        check("R2", "code 6 count", count_q, 0);
    endtask

    task automatic t_mode3();
        wr_mode(3'd3);
        wr_preset(16'd5);
        check("R7", "odd trimmed", count_q, 4);
        check("R7", "start out", wave_out, 1);
        step_clk(1);
        check("R7", "step by two", count_q, 2);
        step_clk(1);
        check("R7", "reload", count_q, 4);
        check("R7", "toggle low", wave_out, 0);
        step_clk(2);
        check("R7", "toggle high", wave_out, 1);
        step_clk(1);
        gate_pulse();
        check("R13", "gate restart", count_q, 4);
        wr_mode(3'd7);
        wr_preset(16'd0);
        step_clk(1);
        check("R7", "preset 0 wrap", count_q, 16'hFFFE);
        wr_preset(16'd1);
        check("R11", "square refuse flag", preset_err, 1);
        check("R11", "square refuse count", count_q, 16'hFFFE);
    endtask

    task automatic t_mode4();
        wr_mode(3'd4);
        check("R2", "mode4 out high", wave_out, 1);
        wr_preset(16'd3);
        check("R8", "load count", count_q, 3);
        gate_pulse();
        check("R10", "mode4 gate count", count_q, 3);
        step_clk(2);
        check("R8", "count 1 out", wave_out, 1);
        step_clk(1);
        check("R8", "strobe count", count_q, 0);
        check("R8", "strobe low", wave_out, 0);
        step_clk(1);
        check("R8", "strobe end", wave_out, 1);
        step_clk(1);
        check("R8", "idle count", count_q, 0);
        check("R8", "idle out", wave_out, 1);
    endtask

    task automatic t_mode5();
        wr_mode(3'd5);
        wr_preset(16'd2);
        step_clk(1);
        check("R9", "armed no count", count_q, 0);
        gate_pulse();
        check("R9", "trigger count", count_q, 2);
        check("R9", "trigger out", wave_out, 1);
        step_clk(2);
        check("R9", "strobe low", wave_out, 0);
        step_clk(1);
        check("R9", "strobe end", wave_out, 1);
        gate_pulse();
        check("R9", "re-armed trigger", count_q, 2);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_mode0();
        t_mode1();
        t_mode2();
        t_mode3();
        t_mode4();
        t_mode5();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule